// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block takes a PLL controller from whatever state it is in to locked operation with its output dividers aligned. It needs no processor. A single-cycle `start` pulse captures a configuration: a multiplier, a pre-divider and a post-divider (each with a present flag), a mask of the output dividers that are in use, and the address of an external status word. The block then works through a fixed script of register reads and writes on a simple memory-mapped master port.

The script has four stages:
1. Read the control word once. Use read-modify-write to power the PLL up, select the internal enable source and drop into bypass.
2. Wait, then pulse the PLL reset for a timed interval.
3. Load the multiplier and any dividers that are present. Issue the four-word unlock pattern. If any output divider is in use, run the alignment GO handshake.
4. Clear the command word. Wait until the external status reports all three ready bits. Leave bypass and raise `done` for one cycle.

Every access holds its address, data and strobe until the slave answers with `bus_ready`.

The control word sits at `BASE_ADDR + 0x100`. Bit positions in it are fixed:

| Bit | Meaning |
|-----|---------|
| 0 | enable; a 0 means bypass |
| 1 | power-down |
| 3 | PLL reset |
| 5 | enable-source select |

Top module: `pll_bringup_seq`

## Requirements
- R1: While reset is held, and after its release until `start`, `bus_wr`, `bus_rd` and `done` stay low.
- R2: After `start` the block reads `BASE_ADDR+0x100` once. It then writes that address three times: first clearing bit 1, then also bit 5, then also bit 0. Every other bit keeps the value that was read.
- R3: The control write that sets bit 3 comes at least `REF_WAIT_CLKS` cycles after the bypass write. The following write that clears bit 3 comes at least `5*CLKS_PER_US` cycles after the set write.
- R4: `BASE_ADDR+0x110` receives `(cfg_mult >> 1) & 0x1FF`.
- R5: The pre-divider write, `cfg_prediv-1` to `+0x114`, occurs only when `cfg_prediv_en` is 1. The post-divider write, `0x8000 | (cfg_postdiv-1)` to `+0x128`, occurs only when `cfg_postdiv_en` is 1. Divider values lie in 1..255.
- R6: `BASE_ADDR+0x108` then receives exactly `0x00470000`, `0x00460000`, `0x00400000`, `0x00410000`, in that order.
- R7: If `cfg_div_mask` is nonzero, the block writes the mask, zero-extended, to `+0x140` and `0x01` to `+0x138`. It then reads `+0x13C` repeatedly until bit 0 reads 0. If the mask is zero, none of these accesses occurs.
- R8: The block then writes `0x00` to `+0x138` and reads `cfg_stat_addr` repeatedly until bits 27:25 are all 1. A value with only some of those bits set keeps the polling going.
- R9: The last write sets bit 0 of the control word. It leaves bit 3 clear and keeps the other bits from the first read. One cycle later or after, `done` is high for exactly one cycle, with no strobe active.
- R10: Once raised, `bus_wr` or `bus_rd` stays high, with address and data stable, until a cycle with `bus_ready` high. The two strobes are never high together.
- R11: A `start` during a sequence changes neither the captured configuration nor the access script. After `done` no further access occurs until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a bring-up (sampled only when idle) |
| cfg_mult | input | 16 | PLL multiplier |
| cfg_prediv_en | input | 1 | pre-divider present |
| cfg_prediv | input | 8 | pre-divider value |
| cfg_postdiv_en | input | 1 | post-divider present |
| cfg_postdiv | input | 8 | post-divider value |
| cfg_div_mask | input | 9 | output dividers in use |
| cfg_stat_addr | input | 32 | address of the external ready word |
| bus_addr | output | 32 | access address |
| bus_wdata | output | 32 | write data |
| bus_wr | output | 1 | write strobe |
| bus_rd | output | 1 | read strobe |
| bus_rdata | input | 32 | read data, valid with `bus_ready` |
| bus_ready | input | 1 | slave completes the pending access |
| done | output | 1 | single-cycle completion pulse |

## Verification
A step decoder that skips or repeats a state shows up at once in the write log, as a missing, doubled or out-of-order entry. A shadow control word that is stale or wrongly masked corrupts one of the control writes within the first few accesses. A timer that loads the wrong count moves the reset-set and reset-clear writes closer together than the hold window, which is visible in their logged cycle stamps. Poll logic that tests the wrong bits ends polling early or late, so the count of status reads differs from the number of busy replies the slave gave.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int PLL_AW  = 32;
    localparam int PLL_DW  = 32;
    localparam int MULT_W  = 16;
    localparam int DIV_W   = 8;
    localparam int NUM_DIV = 9;

    localparam logic [PLL_AW-1:0] OFS_CTL  = 32'h100;
    localparam logic [PLL_AW-1:0] OFS_KEY  = 32'h108;
    localparam logic [PLL_AW-1:0] OFS_MULT = 32'h110;
    localparam logic [PLL_AW-1:0] OFS_PRE  = 32'h114;
    localparam logic [PLL_AW-1:0] OFS_POST = 32'h128;
    localparam logic [PLL_AW-1:0] OFS_CMD  = 32'h138;
    localparam logic [PLL_AW-1:0] OFS_GOST = 32'h13C;
    localparam logic [PLL_AW-1:0] OFS_ALN  = 32'h140;

    localparam int CTL_EN  = 0;
    localparam int CTL_PD  = 1;
    localparam int CTL_RST = 3;
    localparam int CTL_SRC = 5;

    localparam logic [PLL_DW-1:0] DIV_ON   = 32'h0000_8000;
    localparam logic [PLL_DW-1:0] MULT_MSK = 32'h0000_01FF;

    typedef struct packed {
        logic [MULT_W-1:0]  mult;
        logic               pre_en;
        logic [DIV_W-1:0]   pre;
        logic               post_en;
        logic [DIV_W-1:0]   post;
        logic [NUM_DIV-1:0] mask;
        logic [PLL_AW-1:0]  stat_addr;
    } seq_cfg_t;

    typedef enum logic [4:0] {
        ST_IDLE, ST_RD_CTL, ST_PWR_UP, ST_SRC_CLR, ST_BYPASS, ST_REF_WAIT,
        ST_RST_ON, ST_RST_HOLD, ST_RST_OFF, ST_MULT, ST_PRE, ST_POST,
        ST_KEY0, ST_KEY1, ST_KEY2, ST_KEY3, ST_ALIGN, ST_GO, ST_GO_POLL,
        ST_CMD_CLR, ST_LOCK_POLL, ST_RUN, ST_DONE
    } step_t;

    function automatic logic [PLL_DW-1:0] key_word(input logic [1:0] idx);
        case (idx)
            2'd0:    return 32'h0047_0000;
            2'd1:    return 32'h0046_0000;
            2'd2:    return 32'h0040_0000;
            default: return 32'h0041_0000;
        endcase
    endfunction

    function automatic logic lock_ok(input logic [PLL_DW-1:0] d);
        return &d[27:25];
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - TW'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pll_seq_bus.sv
module pll_seq_bus
    import pll_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_we,
    input  logic [PLL_AW-1:0] req_addr,
    input  logic [PLL_DW-1:0] req_data,
    output logic              ack,
    output logic [PLL_DW-1:0] ack_data,
    output logic [PLL_AW-1:0] bus_addr,
    output logic [PLL_DW-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [PLL_DW-1:0] bus_rdata,
    input  logic              bus_ready
);
    logic active;
    assign active = bus_wr | bus_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_wr    <= 1'b0;
            bus_rd    <= 1'b0;
            ack       <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            ack_data  <= '0;
        end else begin
            ack <= 1'b0;
            if (active && bus_ready) begin
                bus_wr   <= 1'b0;
                bus_rd   <= 1'b0;
                ack      <= 1'b1;
                ack_data <= bus_rdata;
            end else if (req && !active) begin
                bus_wr    <= req_we;
                bus_rd    <= !req_we;
                bus_addr  <= req_addr;
                bus_wdata <= req_data;
            end
        end
    end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter logic [PLL_AW-1:0] BASE_ADDR = 32'h0,
    parameter int                TW        = 10,
    parameter int                REF_CLKS  = 8,
    parameter int                HOLD_CLKS = 625
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  seq_cfg_t          cfg_in,
    output logic              req,
    output logic              req_we,
    output logic [PLL_AW-1:0] req_addr,
    output logic [PLL_DW-1:0] req_data,
    input  logic              ack,
    input  logic [PLL_DW-1:0] ack_data,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    input  logic              tmr_zero,
    output logic              done
);
    step_t             state, nxt;
    seq_cfg_t          cfg;
    logic              pend;
    logic [PLL_DW-1:0] shadow;

    logic              acc, wt, abs_addr, ctl_wr, poll_ok;
    logic [PLL_AW-1:0] ofs;
    logic [PLL_DW-1:0] d;
    logic [DIV_W-1:0]  pre_m1, post_m1;

    assign pre_m1  = cfg.pre  - DIV_W'(1);
    assign post_m1 = cfg.post - DIV_W'(1);

    always_comb begin
        acc      = 1'b0;
        wt       = 1'b0;
        req_we   = 1'b0;
        abs_addr = 1'b0;
        ctl_wr   = 1'b0;
        ofs      = OFS_CTL;
        d        = shadow;
        tmr_val  = '0;
        nxt      = state;
        case (state)
            ST_RD_CTL:   begin acc = 1'b1; nxt = ST_PWR_UP; end
            ST_PWR_UP:   begin acc = 1'b1; req_we = 1'b1; ctl_wr = 1'b1;
                               d[CTL_PD] = 1'b0; nxt = ST_SRC_CLR; end
            ST_SRC_CLR:  begin acc = 1'b1; req_we = 1'b1; ctl_wr = 1'b1;
                               d[CTL_SRC] = 1'b0; nxt = ST_BYPASS; end
            ST_BYPASS:   begin acc = 1'b1; req_we = 1'b1; ctl_wr = 1'b1;
                               d[CTL_EN] = 1'b0; nxt = ST_REF_WAIT; end
            ST_REF_WAIT: begin wt = 1'b1; tmr_val = TW'(REF_CLKS); nxt = ST_RST_ON; end
            ST_RST_ON:   begin acc = 1'b1; req_we = 1'b1; ctl_wr = 1'b1;
                               d[CTL_RST] = 1'b1; nxt = ST_RST_HOLD; end
            ST_RST_HOLD: begin wt = 1'b1; tmr_val = TW'(HOLD_CLKS); nxt = ST_RST_OFF; end
            ST_RST_OFF:  begin acc = 1'b1; req_we = 1'b1; ctl_wr = 1'b1;
                               d[CTL_RST] = 1'b0; nxt = ST_MULT; end
            ST_MULT: begin
                acc = 1'b1; req_we = 1'b1; ofs = OFS_MULT;
                d   = PLL_DW'(cfg.mult >> 1) & MULT_MSK;
                nxt = cfg.pre_en ? ST_PRE : (cfg.post_en ? ST_POST : ST_KEY0);
            end
            ST_PRE: begin
                acc = 1'b1; req_we = 1'b1; ofs = OFS_PRE;
                d   = PLL_DW'(pre_m1);
                nxt = cfg.post_en ? ST_POST : ST_KEY0;
            end
            ST_POST: begin
                acc = 1'b1; req_we = 1'b1; ofs = OFS_POST;
                d   = DIV_ON | PLL_DW'(post_m1);
                nxt = ST_KEY0;
            end
            ST_KEY0: begin acc = 1'b1; req_we = 1'b1; ofs = OFS_KEY;
                           d = key_word(2'd0); nxt = ST_KEY1; end
            ST_KEY1: begin acc = 1'b1; req_we = 1'b1; ofs = OFS_KEY;
                           d = key_word(2'd1); nxt = ST_KEY2; end
            ST_KEY2: begin acc = 1'b1; req_we = 1'b1; ofs = OFS_KEY;
                           d = key_word(2'd2); nxt = ST_KEY3; end
            ST_KEY3: begin
                acc = 1'b1; req_we = 1'b1; ofs = OFS_KEY; d = key_word(2'd3);
                nxt = (|cfg.mask) ? ST_ALIGN : ST_CMD_CLR;
            end
            ST_ALIGN:    begin acc = 1'b1; req_we = 1'b1; ofs = OFS_ALN;
                               d = PLL_DW'(cfg.mask); nxt = ST_GO; end
            ST_GO:       begin acc = 1'b1; req_we = 1'b1; ofs = OFS_CMD;
                               d = PLL_DW'(1); nxt = ST_GO_POLL; end
            ST_GO_POLL:  begin acc = 1'b1; ofs = OFS_GOST; nxt = ST_CMD_CLR; end
            ST_CMD_CLR:  begin acc = 1'b1; req_we = 1'b1; ofs = OFS_CMD;
                               d = '0; nxt = ST_LOCK_POLL; end
            ST_LOCK_POLL: begin acc = 1'b1; abs_addr = 1'b1; nxt = ST_RUN; end
            ST_RUN:      begin acc = 1'b1; req_we = 1'b1; ctl_wr = 1'b1;
                               d[CTL_EN] = 1'b1; nxt = ST_DONE; end
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = state;
        endcase
    end

    always_comb begin
        case (state)
            ST_GO_POLL:   poll_ok = !ack_data[0];
            ST_LOCK_POLL: poll_ok = lock_ok(ack_data);
            default:      poll_ok = 1'b1;
        endcase
    end

    assign req      = acc && !pend;
    assign req_addr = abs_addr ? cfg.stat_addr : (BASE_ADDR + ofs);
    assign req_data = d;
    assign tmr_load = wt && !pend;
    assign done     = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            shadow <= '0;
            cfg    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    pend <= 1'b0;
                    if (start) begin
                        cfg   <= cfg_in;
                        state <= ST_RD_CTL;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: begin
                    if (acc) begin
                        if (!pend) begin
                            pend <= 1'b1;
                        end else if (ack) begin
                            pend <= 1'b0;
                            if (poll_ok)
                                state <= nxt;
                            if (state == ST_RD_CTL)
                                shadow <= ack_data;
                            else if (ctl_wr)
                                shadow <= d;
                        end
                    end else if (wt) begin
                        if (!pend) begin
                            pend <= 1'b1;
                        end else if (tmr_zero) begin
                            pend  <= 1'b0;
                            state <= nxt;
                        end
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pll_seq_pkg::*;
#(
    parameter logic [PLL_AW-1:0] BASE_ADDR     = 32'h01C4_0800,
    parameter int                REF_WAIT_CLKS = 8,
    parameter int                CLKS_PER_US   = 125
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [MULT_W-1:0]  cfg_mult,
    input  logic               cfg_prediv_en,
    input  logic [DIV_W-1:0]   cfg_prediv,
    input  logic               cfg_postdiv_en,
    input  logic [DIV_W-1:0]   cfg_postdiv,
    input  logic [NUM_DIV-1:0] cfg_div_mask,
    input  logic [PLL_AW-1:0]  cfg_stat_addr,
    output logic [PLL_AW-1:0]  bus_addr,
    output logic [PLL_DW-1:0]  bus_wdata,
    output logic               bus_wr,
    output logic               bus_rd,
    input  logic [PLL_DW-1:0]  bus_rdata,
    input  logic               bus_ready,
    output logic               done
);
    localparam int HOLD_CLKS = 5 * CLKS_PER_US;
    localparam int TMR_MAX   = (HOLD_CLKS > REF_WAIT_CLKS) ? HOLD_CLKS : REF_WAIT_CLKS;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);
    localparam logic [PLL_AW-1:0] CTL_ADDR_C = BASE_ADDR + OFS_CTL;
    localparam logic [31:0]       HOLD_C     = 32'(HOLD_CLKS);

    seq_cfg_t          cfg_bundle;
    logic              req, req_we, ack, tmr_load, tmr_zero;
    logic [PLL_AW-1:0] req_addr;
    logic [PLL_DW-1:0] req_data, ack_data;
    logic [TMR_W-1:0]  tmr_val;

    assign cfg_bundle = '{mult: cfg_mult, pre_en: cfg_prediv_en, pre: cfg_prediv,
                          post_en: cfg_postdiv_en, post: cfg_postdiv,
                          mask: cfg_div_mask, stat_addr: cfg_stat_addr};

    pll_seq_ctrl #(
        .BASE_ADDR(BASE_ADDR), .TW(TMR_W),
        .REF_CLKS(REF_WAIT_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_in(cfg_bundle),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_data(req_data),
        .ack(ack), .ack_data(ack_data),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_zero(tmr_zero),
        .done(done)
    );

    pll_seq_bus u_bus (
        .clk(clk), .rst(rst), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_data(req_data),
        .ack(ack), .ack_data(ack_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    pll_seq_timer #(.TW(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_ready,
    input logic        done,
    input logic [31:0] ctl_addr,
    input logic [31:0] hold_clks
);
    logic        rst_on;
    logic [31:0] rst_cnt;
    logic        ctl_acc;

    assign ctl_acc = bus_wr && bus_ready && (bus_addr == ctl_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_on  <= 1'b0;
            rst_cnt <= '0;
        end else if (ctl_acc && bus_wdata[3]) begin
            rst_on  <= 1'b1;
            rst_cnt <= '0;
        end else if (ctl_acc) begin
            rst_on  <= 1'b0;
        end else if (rst_on && rst_cnt != '1) begin
            rst_cnt <= rst_cnt + 32'd1;
        end
    end

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ready) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ready) |=> (bus_rd && $stable(bus_addr)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_wr && !bus_rd));

    // R3
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_acc && !bus_wdata[3] && rst_on) |-> (rst_cnt >= hold_clks));
endmodule

bind pll_bringup_seq pll_bringup_seq_chk u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ready(bus_ready), .done(done),
    .ctl_addr(CTL_ADDR_C), .hold_clks(HOLD_C)
);

// File: tb/pll_bringup_seq_bench.sv
`timescale 1ns/1ps
module pll_bringup_seq_bench;
    localparam logic [31:0] BASE = 32'h01C4_0800;
    localparam int          REFW = 8;
    localparam int          CPU  = 125;
    localparam int          HOLD = 5 * CPU;
    localparam logic [31:0] A_CTL = BASE + 32'h100;
    localparam logic [31:0] A_GOS = BASE + 32'h13C;

    logic        clk = 0, rst = 1, start = 0;
    logic [15:0] cfg_mult = 0;
    logic        cfg_prediv_en = 0, cfg_postdiv_en = 0;
    logic [7:0]  cfg_prediv = 1, cfg_postdiv = 1;
    logic [8:0]  cfg_div_mask = 0;
    logic [31:0] cfg_stat_addr = 32'h01C4_0044;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
    logic        bus_wr, bus_rd, bus_ready = 0, done;

    always #4 clk = ~clk;

    pll_bringup_seq #(.BASE_ADDR(BASE), .REF_WAIT_CLKS(REFW), .CLKS_PER_US(CPU)) u_pll_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_mult(cfg_mult),
        .cfg_prediv_en(cfg_prediv_en), .cfg_prediv(cfg_prediv),
        .cfg_postdiv_en(cfg_postdiv_en), .cfg_postdiv(cfg_postdiv),
        .cfg_div_mask(cfg_div_mask), .cfg_stat_addr(cfg_stat_addr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done));

    int checks = 0, fails = 0;
    int cyc = 0, wait_c = 0, acc_cnt = 0;
    int go_reads = 0, lock_reads = 0, go_busy = 0, lock_busy = 0;
    int done_cnt = 0, done_cyc = 0, hold_err = 0, both_err = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_cyc  [64];
    int          nlog = 0;
    logic [31:0] exp_addr [64];
    logic [31:0] exp_data [64];
    string       exp_tag  [64];
    int          nexp = 0;
    logic        prev_pend = 0;
    logic [31:0] prev_addr = 0, prev_data = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] slave_read(input logic [31:0] a);
        logic [31:0] v;
        if (a == A_GOS) begin
            v = (go_reads < go_busy) ? 32'h1 : 32'h0;
            go_reads++;
        end else if (a == cfg_stat_addr) begin
            v = (lock_reads < lock_busy) ? 32'h0600_5555 : 32'h0E00_1234;
            lock_reads++;
        end else begin
            v = mem.exists(a) ? mem[a] : 32'h0;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (done) begin done_cnt++; done_cyc = cyc; end
        if (bus_wr && bus_rd) both_err++;
        if (prev_pend && !(bus_wr || bus_rd)) hold_err++;
        if (prev_pend && (bus_addr != prev_addr || bus_wdata != prev_data)) hold_err++;
        prev_pend = (bus_wr || bus_rd) && !bus_ready;
        prev_addr = bus_addr;
        prev_data = bus_wdata;
        if (bus_ready && bus_wr) begin
            if (nlog < 64) begin
                log_addr[nlog] = bus_addr;
                log_data[nlog] = bus_wdata;
                log_cyc[nlog]  = cyc;
            end
            nlog++;
            mem[bus_addr] = bus_wdata;
        end
        bus_ready <= 1'b0;
        if ((bus_wr || bus_rd) && !bus_ready) begin
            if (wait_c == 0) begin
                bus_ready <= 1'b1;
                if (bus_rd) bus_rdata <= slave_read(bus_addr);
                acc_cnt++;
                wait_c = acc_cnt % 3;
            end else begin
                wait_c = wait_c - 1;
            end
        end
    end

    task automatic push(input logic [31:0] a, input logic [31:0] d, input string t);
        exp_addr[nexp] = a; exp_data[nexp] = d; exp_tag[nexp] = t; nexp++;
    endtask

    task automatic run_cfg(input logic [31:0] init, input logic [15:0] mult,
                           input bit pe, input logic [7:0] pv, input bit po, input logic [7:0] ov,
                           input logic [8:0] mask, input int gb, input int lb, input bit inject);
        logic [31:0] c;
        int t, n0, bypass_i, rst_i;
        mem.delete();
        mem[A_CTL] = init;
        nlog = 0; nexp = 0; go_reads = 0; lock_reads = 0; done_cnt = 0;
        go_busy = gb; lock_busy = lb;
        c = init;
        c = c & ~32'h2;  push(A_CTL, c, "R2");
        c = c & ~32'h20; push(A_CTL, c, "R2");
        c = c & ~32'h1;  push(A_CTL, c, "R2"); bypass_i = nexp - 1;
        c = c | 32'h8;   push(A_CTL, c, "R3"); rst_i = nexp - 1;
        c = c & ~32'h8;  push(A_CTL, c, "R3");
        push(BASE + 32'h110, {16'h0, mult} / 2 % 512, "R4");
        if (pe) push(BASE + 32'h114, {24'h0, pv} - 1, "R5");
        if (po) push(BASE + 32'h128, 32'h8000 + {24'h0, ov} - 1, "R5");
        push(BASE + 32'h108, 32'h0047_0000, "R6");
        push(BASE + 32'h108, 32'h0046_0000, "R6");
        push(BASE + 32'h108, 32'h0040_0000, "R6");
        push(BASE + 32'h108, 32'h0041_0000, "R6");
        if (mask != 0) begin
            push(BASE + 32'h140, {23'h0, mask}, "R7");
            push(BASE + 32'h138, 32'h1, "R7");
        end
        push(BASE + 32'h138, 32'h0, "R8");
        c = c | 32'h1;   push(A_CTL, c, "R9");

        @(negedge clk);
        cfg_mult = mult; cfg_prediv_en = pe; cfg_prediv = pv;
        cfg_postdiv_en = po; cfg_postdiv = ov; cfg_div_mask = mask;
        start = 1;
        @(negedge clk);
        start = 0;
        t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(negedge clk);
            t++;
            if (inject && t == 30) begin
                cfg_mult = ~mult; cfg_prediv_en = ~pe; cfg_postdiv_en = ~po;
                cfg_div_mask = ~mask; start = 1;
            end
            if (inject && t == 31) start = 0;
        end
        check(done_cnt != 0, "R9", "done reached", 32'(done_cnt), 32'd1);
        n0 = nlog;
        repeat (20) @(negedge clk);
        check(done_cnt == 1, "R9", "done pulse count", 32'(done_cnt), 32'd1);
        check(nlog == n0 && !bus_wr && !bus_rd, "R11", "quiet after done", 32'(nlog), 32'(n0));
        check(nlog == nexp, "R2", "write count", 32'(nlog), 32'(nexp));
        for (int i = 0; i < nexp && i < nlog; i++) begin
            check(log_addr[i] == exp_addr[i], exp_tag[i], $sformatf("addr #%0d", i),
                  log_addr[i], exp_addr[i]);
            check(log_data[i] == exp_data[i], exp_tag[i], $sformatf("data #%0d", i),
                  log_data[i], exp_data[i]);
        end
        if (nlog > rst_i + 1) begin
            check(log_cyc[rst_i] - log_cyc[bypass_i] >= REFW, "R3", "ref wait",
                  32'(log_cyc[rst_i] - log_cyc[bypass_i]), 32'(REFW));
            check(log_cyc[rst_i + 1] - log_cyc[rst_i] >= HOLD, "R3", "reset hold",
                  32'(log_cyc[rst_i + 1] - log_cyc[rst_i]), 32'(HOLD));
        end
        if (nlog > 0 && nlog <= 64)
            check(done_cyc > log_cyc[nlog - 1], "R9", "done after last write",
                  32'(done_cyc), 32'(log_cyc[nlog - 1]));
        check(go_reads == ((mask != 0) ? gb + 1 : 0), "R7", "GO status reads",
              32'(go_reads), 32'((mask != 0) ? gb + 1 : 0));
        check(lock_reads == lb + 1, "R8", "ready status reads", 32'(lock_reads), 32'(lb + 1));
        check(hold_err == 0 && both_err == 0, "R10", "strobe hold / exclusive",
              32'(hold_err + both_err), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!bus_wr && !bus_rd && !done, "R1", "outputs in reset",
              {29'h0, bus_wr, bus_rd, done}, 32'h0);
        rst = 0;
        repeat (6) begin
            @(negedge clk);
            check(!bus_wr && !bus_rd && !done, "R1", "idle after reset",
                  {29'h0, bus_wr, bus_rd, done}, 32'h0);
        end
        for (int k = 0; k < 12; k++) begin
            logic [8:0] m;
            m = (k % 3 == 0) ? 9'h000 : ((k % 3 == 1) ? 9'h001 : 9'h1FF);
            cfg_stat_addr = k[0] ? 32'h01C4_0044 : 32'h0200_0010;
            run_cfg((k % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0023 ^ (32'(k) << 8),
                    16'(37 * k + 2 + k * 300), k[1], 8'(k + 1), k[2] ^ k[3], 8'(255 - k),
                    m, k % 4, k % 3, 1'b0);
        end
        cfg_stat_addr = 32'h01C4_0044;
        run_cfg(32'h0000_0A0B, 16'h03FF, 1'b1, 8'd255, 1'b1, 8'd1, 9'h055, 2, 3, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule